// File: doc/BRIEF.md
# Power-Management Companion Register Bank

This block holds the 32-slot, 16-bit register space of a power-management companion device, reached through a simple serial-bus slave port. Each access is a one-cycle strobe carrying a register index, a write flag and write data. Read data comes back registered on the cycle after the strobe and holds there until the next read. The bank raises a level interrupt whenever an unmasked pending flag exists, and it requests a system shutdown when the watchdog is stopped while its enable bit is armed.

Its hardware inputs are a power-key event with the current key level, a load port that fills a per-channel ADC result table, and a set of sample flags. A write to the ADC register selects a channel and posts an ADC-done interrupt. Reading that register returns the channel number together with the channel's stored result. Registers that are defined but not implemented read as zero. Indices that are not defined at all raise a one-cycle error pulse.

Top module: `pmic_regbank`

## Requirements
- R1: `irq_o` is high exactly when some pending flag bit has a 0 in the same position of the mask register (index 0x02). It follows the registers in the cycle they change.
- R2: After reset the mask reads 0xFFFF, the pending flags read 0x0000, the sample flags read 0x0000, and `irq_o`, `shutdown_req_o`, `bad_index_o` and `acc_rdata_o` are 0.
- R3: A write to index 0x01 XORs the written value into the pending flags, and a read of 0x01 returns the flags. Index 0x02 is the mask, which can be read and written.
- R4: Index 0x00 reads 0x0215 with bit 7 set when the parameter `VARIANT` is nonzero.
- R5: A write to index 0x08 latches the channel from write-data bits [13:10] and sets pending flag bit 8.
- R6: A read of index 0x08 returns the latched channel in bits [13:10], ORed with that channel's 10-bit result from the load port. Table entries reset to 0.
- R7: Index 0x09 collects the bits of `smp_set_i`. Writing it clears every bit written as 1. A bit set by `smp_set_i` in the same cycle stays set.
- R8: Writing 0x0000 to index 0x17 while bit 1 of index 0x0D is 1 drives `shutdown_req_o` high for one cycle. Any other write to 0x17 does nothing.
- R9: Index 0x16 resets to 0x0020 and ignores writes. A key event sets pending flag bit 0 and loads bit 5 of 0x16 with the inverse of `key_pressed_i`. Index 0x06 resets to 0x0001. Indices 0x06, 0x0D and 0x0E can be read and written.
- R10: An access to index 0x07 or 0x12 to 0x15 drives `bad_index_o` high for exactly the following cycle, and a read of such an index returns 0.
- R11: Defined but unimplemented indices (0x03-0x05, 0x0A-0x0C, 0x0F-0x11, 0x17-0x1F) read 0, and writes to them change no other register.
- R12: A hardware flag set (key event) in the same cycle as an XOR write to 0x01 leaves that flag bit at 1.
- R13: `acc_rdata_o` updates only on the cycle after a read strobe and holds its value across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid_i | input | 1 | One-cycle access strobe |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_index_i | input | 5 | Register index |
| acc_wdata_i | input | 16 | Write data |
| acc_rdata_o | output | 16 | Registered read data |
| key_event_i | input | 1 | Power-key change pulse |
| key_pressed_i | input | 1 | Key level sampled with the event |
| adc_load_i | input | 1 | Load strobe for the result table |
| adc_load_chan_i | input | 4 | Table entry to load |
| adc_load_val_i | input | 10 | Result value to load |
| smp_set_i | input | 16 | Sample-flag set bits |
| irq_o | output | 1 | Level interrupt |
| shutdown_req_o | output | 1 | One-cycle shutdown request |
| bad_index_o | output | 1 | One-cycle undefined-index pulse |

## Verification
The hardest cases to reach from the ports are cycles where two writers hit the same state at once. One is a key event landing together with an XOR write that would clear the same flag. The other is a sample-flag set arriving in the cycle that clears it. The stimulus drives both sides in a single cycle so that the set-over-clear rule becomes visible on a later read. The shutdown path needs the control register armed beforehand, so the bench first shows that a zero write does nothing while unarmed, and that a nonzero write does nothing while armed.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int REG_W = 16;
  localparam int IDX_W = 5;

  localparam logic [IDX_W-1:0] IDX_CHIPID    = 5'h00;
  localparam logic [IDX_W-1:0] IDX_IRQ_FLAGS = 5'h01;
  localparam logic [IDX_W-1:0] IDX_IRQ_MASK  = 5'h02;
  localparam logic [IDX_W-1:0] IDX_CAL       = 5'h06;
  localparam logic [IDX_W-1:0] IDX_ADC_DATA  = 5'h08;
  localparam logic [IDX_W-1:0] IDX_ADC_SMP   = 5'h09;
  localparam logic [IDX_W-1:0] IDX_CTRL_A    = 5'h0D;
  localparam logic [IDX_W-1:0] IDX_CTRL_B    = 5'h0E;
  localparam logic [IDX_W-1:0] IDX_STAT      = 5'h16;
  localparam logic [IDX_W-1:0] IDX_WDOG      = 5'h17;

  localparam logic [REG_W-1:0] CHIPID_BASE = 16'h0215;
  localparam int VARIANT_BIT  = 7;
  localparam int FLAG_KEY     = 0;
  localparam int FLAG_ADC     = 8;
  localparam int STAT_KEY_BIT = 5;
  localparam int WDOG_ARM_BIT = 1;
  localparam logic [REG_W-1:0] STAT_RESET = 16'h0020;
  localparam logic [REG_W-1:0] CAL_RESET  = 16'h0001;

  typedef struct packed {
    logic rd;
    logic wr_flags;
    logic wr_mask;
    logic wr_cal;
    logic wr_adc;
    logic wr_smp;
    logic wr_ctrl_a;
    logic wr_ctrl_b;
    logic wr_wdog;
    logic bad;
  } acc_dec_t;

  function automatic logic idx_undefined(input logic [IDX_W-1:0] i);
    return (i == 5'h07) || ((i >= 5'h12) && (i <= 5'h15));
  endfunction
endpackage

// File: rtl/pmic_access_decode.sv
module pmic_access_decode
  import pmic_pkg::*;
(
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [IDX_W-1:0] index_i,
  output acc_dec_t         dec_o
);
  logic wr;

  always_comb begin
    wr              = valid_i && write_i;
    dec_o           = '0;
    dec_o.rd        = valid_i && !write_i;
    dec_o.bad       = valid_i && idx_undefined(index_i);
    dec_o.wr_flags  = wr && (index_i == IDX_IRQ_FLAGS);
    dec_o.wr_mask   = wr && (index_i == IDX_IRQ_MASK);
    dec_o.wr_cal    = wr && (index_i == IDX_CAL);
    dec_o.wr_adc    = wr && (index_i == IDX_ADC_DATA);
    dec_o.wr_smp    = wr && (index_i == IDX_ADC_SMP);
    dec_o.wr_ctrl_a = wr && (index_i == IDX_CTRL_A);
    dec_o.wr_ctrl_b = wr && (index_i == IDX_CTRL_B);
    dec_o.wr_wdog   = wr && (index_i == IDX_WDOG);
  end
endmodule

// File: rtl/pmic_irq_unit.sv
module pmic_irq_unit
  import pmic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xor_we_i,
  input  logic             mask_we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] hw_set_i,
  output logic [REG_W-1:0] flags_o,
  output logic [REG_W-1:0] mask_o,
  output logic             irq_o
);
  logic [REG_W-1:0] flags_q, flags_d;
  logic [REG_W-1:0] mask_q;
  logic             flags_en;

  always_comb begin
    flags_en = xor_we_i || (|hw_set_i);
    flags_d  = (flags_q ^ (xor_we_i ? wdata_i : '0)) | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '1;
    end else begin
      if (flags_en)  flags_q <= flags_d;
      if (mask_we_i) mask_q  <= wdata_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & ~mask_q);
endmodule

// File: rtl/pmic_adc_unit.sv
module pmic_adc_unit
  import pmic_pkg::*;
#(
  parameter int CHANNELS = 16,
  parameter int RES_W    = 10,
  parameter int CHAN_LSB = 10,
  localparam int CH_W    = $clog2(CHANNELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CH_W-1:0]  load_chan_i,
  input  logic [RES_W-1:0] load_val_i,
  input  logic             sel_we_i,
  input  logic [CH_W-1:0]  sel_chan_i,
  input  logic             smp_clr_we_i,
  input  logic [REG_W-1:0] smp_clr_i,
  input  logic [REG_W-1:0] smp_set_i,
  output logic [REG_W-1:0] data_word_o,
  output logic [REG_W-1:0] smp_o
);
  logic [RES_W-1:0] table_q [CHANNELS];
  logic [CH_W-1:0]  chan_q;
  logic [REG_W-1:0] smp_q, smp_d;
  logic             smp_en;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     table_q[c] <= '0;
      else if (load_i && (load_chan_i == CH_W'(c)))    table_q[c] <= load_val_i;
    end
  end

  always_comb begin
    smp_en = smp_clr_we_i || (|smp_set_i);
    smp_d  = (smp_q & ~(smp_clr_we_i ? smp_clr_i : '0)) | smp_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      smp_q  <= '0;
    end else begin
      if (sel_we_i) chan_q <= sel_chan_i;
      if (smp_en)   smp_q  <= smp_d;
    end
  end

  always_comb begin
    data_word_o = '0;
    data_word_o[CHAN_LSB +: CH_W] = chan_q;
    data_word_o[RES_W-1:0] = data_word_o[RES_W-1:0] | table_q[chan_q];
  end

  assign smp_o = smp_q;
endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
  import pmic_pkg::*;
#(
  parameter int VARIANT     = 0,
  parameter int ADC_CHANNELS = 16,
  parameter int ADC_RES_W   = 10,
  parameter int ADC_CHAN_LSB = 10,
  parameter int SYNC_STAGES = 2,
  localparam int ADC_CH_W   = $clog2(ADC_CHANNELS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [IDX_W-1:0]     acc_index_i,
  input  logic [REG_W-1:0]     acc_wdata_i,
  output logic [REG_W-1:0]     acc_rdata_o,
  input  logic                 key_event_i,
  input  logic                 key_pressed_i,
  input  logic                 adc_load_i,
  input  logic [ADC_CH_W-1:0]  adc_load_chan_i,
  input  logic [ADC_RES_W-1:0] adc_load_val_i,
  input  logic [REG_W-1:0]     smp_set_i,
  output logic                 irq_o,
  output logic                 shutdown_req_o,
  output logic                 bad_index_o
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_sync;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[SYNC_STAGES-1];

  acc_dec_t dec;

  pmic_access_decode u_dec (
    .valid_i (acc_valid_i),
    .write_i (acc_write_i),
    .index_i (acc_index_i),
    .dec_o   (dec)
  );

  logic [REG_W-1:0] hw_set;
  logic [REG_W-1:0] irq_flags, irq_mask;

  always_comb begin
    hw_set           = '0;
    hw_set[FLAG_KEY] = key_event_i;
    hw_set[FLAG_ADC] = dec.wr_adc;
  end

  pmic_irq_unit u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .xor_we_i  (dec.wr_flags),
    .mask_we_i (dec.wr_mask),
    .wdata_i   (acc_wdata_i),
    .hw_set_i  (hw_set),
    .flags_o   (irq_flags),
    .mask_o    (irq_mask),
    .irq_o     (irq_o)
  );

  logic [REG_W-1:0] adc_word, smp_flags;

  pmic_adc_unit #(
    .CHANNELS (ADC_CHANNELS),
    .RES_W    (ADC_RES_W),
    .CHAN_LSB (ADC_CHAN_LSB)
  ) u_adc (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_sync),
    .load_i       (adc_load_i),
    .load_chan_i  (adc_load_chan_i),
    .load_val_i   (adc_load_val_i),
    .sel_we_i     (dec.wr_adc),
    .sel_chan_i   (acc_wdata_i[ADC_CHAN_LSB +: ADC_CH_W]),
    .smp_clr_we_i (dec.wr_smp),
    .smp_clr_i    (acc_wdata_i),
    .smp_set_i    (smp_set_i),
    .data_word_o  (adc_word),
    .smp_o        (smp_flags)
  );

  logic [REG_W-1:0] cal_q, ctrl_a_q, ctrl_b_q, stat_q, stat_d;
  logic [REG_W-1:0] rdata_q, rdata_d;
  logic             shutdown_q, shutdown_d;
  logic             bad_q;
  logic [REG_W-1:0] chip_id;

  assign chip_id = CHIPID_BASE | (REG_W'(VARIANT != 0) << VARIANT_BIT);

  always_comb begin
    stat_d               = stat_q;
    stat_d[STAT_KEY_BIT] = !key_pressed_i;
    shutdown_d = dec.wr_wdog && (acc_wdata_i == '0) && ctrl_a_q[WDOG_ARM_BIT];
    unique case (acc_index_i)
      IDX_CHIPID:    rdata_d = chip_id;
      IDX_IRQ_FLAGS: rdata_d = irq_flags;
      IDX_IRQ_MASK:  rdata_d = irq_mask;
      IDX_CAL:       rdata_d = cal_q;
      IDX_ADC_DATA:  rdata_d = adc_word;
      IDX_ADC_SMP:   rdata_d = smp_flags;
      IDX_CTRL_A:    rdata_d = ctrl_a_q;
      IDX_CTRL_B:    rdata_d = ctrl_b_q;
      IDX_STAT:      rdata_d = stat_q;
      default:       rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      cal_q      <= CAL_RESET;
      ctrl_a_q   <= '0;
      ctrl_b_q   <= '0;
      stat_q     <= STAT_RESET;
      rdata_q    <= '0;
      shutdown_q <= 1'b0;
      bad_q      <= 1'b0;
    end else begin
      if (dec.wr_cal)    cal_q    <= acc_wdata_i;
      if (dec.wr_ctrl_a) ctrl_a_q <= acc_wdata_i;
      if (dec.wr_ctrl_b) ctrl_b_q <= acc_wdata_i;
      if (key_event_i)   stat_q   <= stat_d;
      if (dec.rd)        rdata_q  <= rdata_d;
      shutdown_q <= shutdown_d;
      bad_q      <= dec.bad;
    end
  end

  assign acc_rdata_o    = rdata_q;
  assign shutdown_req_o = shutdown_q;
  assign bad_index_o    = bad_q;
endmodule

// File: rtl/pmic_regbank_checker.sv
module pmic_regbank_checker (
  input logic        clk_i,
  input logic        rst_n,
  input logic        acc_valid_i,
  input logic        acc_write_i,
  input logic [4:0]  acc_index_i,
  input logic [15:0] acc_wdata_i,
  input logic        key_event_i,
  input logic [15:0] smp_set_i,
  input logic [15:0] flags,
  input logic [15:0] mask,
  input logic [15:0] smp,
  input logic [15:0] ctrl_a,
  input logic        irq_o,
  input logic        shutdown_req_o,
  input logic        bad_index_o
);
  logic wr_any;
  assign wr_any = acc_valid_i && acc_write_i;

  assert_irq_needs_unmask_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (mask != 16'hFFFF));

  assert_full_mask_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_any && acc_index_i == 5'h02 && acc_wdata_i == 16'hFFFF) |=> !irq_o);

  assert_flag_xor_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_any && acc_index_i == 5'h01) |=>
      flags == (($past(flags) ^ $past(acc_wdata_i)) | {15'd0, $past(key_event_i)}));

  assert_adc_done_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_any && acc_index_i == 5'h08) |=> flags[8]);

  assert_smp_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_any && acc_index_i == 5'h09) |=>
      ((smp & $past(acc_wdata_i) & ~$past(smp_set_i)) == 16'h0000));

  assert_shutdown_source_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    shutdown_req_o |-> $past(wr_any && acc_index_i == 5'h17 &&
                             acc_wdata_i == 16'h0000 && ctrl_a[1]));

  assert_bad_source_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    bad_index_o |-> $past(acc_valid_i && (acc_index_i == 5'h07 ||
                          (acc_index_i >= 5'h12 && acc_index_i <= 5'h15))));

  assert_key_sets_flag_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    key_event_i |=> flags[0]);
endmodule

bind pmic_regbank pmic_regbank_checker u_chk (
  .clk_i          (clk_i),
  .rst_n          (rst_n_sync),
  .acc_valid_i    (acc_valid_i),
  .acc_write_i    (acc_write_i),
  .acc_index_i    (acc_index_i),
  .acc_wdata_i    (acc_wdata_i),
  .key_event_i    (key_event_i),
  .smp_set_i      (smp_set_i),
  .flags          (irq_flags),
  .mask           (irq_mask),
  .smp            (smp_flags),
  .ctrl_a         (ctrl_a_q),
  .irq_o          (irq_o),
  .shutdown_req_o (shutdown_req_o),
  .bad_index_o    (bad_index_o)
);

// File: tb/pmic_regbank_bench.sv
module pmic_regbank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        acc_valid_i, acc_write_i;
  logic [4:0]  acc_index_i;
  logic [15:0] acc_wdata_i;
  logic [15:0] acc_rdata_o;
  logic        key_event_i, key_pressed_i;
  logic        adc_load_i;
  logic [3:0]  adc_load_chan_i;
  logic [9:0]  adc_load_val_i;
  logic [15:0] smp_set_i;
  logic        irq_o, shutdown_req_o, bad_index_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  pmic_regbank #(.VARIANT(1)) u_pmic_regbank (
    .clk_i, .rst_ni, .acc_valid_i, .acc_write_i, .acc_index_i, .acc_wdata_i,
    .acc_rdata_o, .key_event_i, .key_pressed_i, .adc_load_i, .adc_load_chan_i,
    .adc_load_val_i, .smp_set_i, .irq_o, .shutdown_req_o, .bad_index_o
  );

  // {check, write, index, wdata, expected read}
  localparam int NVEC = 28;
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 5'h00, 16'h0000, 16'h0295}, // R4 chip id with variant bit
    {1'b1, 1'b0, 5'h02, 16'h0000, 16'hFFFF}, // R2 mask reset
    {1'b1, 1'b0, 5'h01, 16'h0000, 16'h0000}, // R2 flags reset
    {1'b1, 1'b0, 5'h06, 16'h0000, 16'h0001}, // R9 cal reset
    {1'b1, 1'b0, 5'h16, 16'h0000, 16'h0020}, // R9 status reset
    {1'b0, 1'b1, 5'h02, 16'h00F0, 16'h0000},
    {1'b1, 1'b0, 5'h02, 16'h0000, 16'h00F0}, // R3 mask readback
    {1'b0, 1'b1, 5'h01, 16'h0013, 16'h0000},
    {1'b1, 1'b0, 5'h01, 16'h0000, 16'h0013}, // R3 xor set
    {1'b0, 1'b1, 5'h01, 16'h0003, 16'h0000},
    {1'b1, 1'b0, 5'h01, 16'h0000, 16'h0010}, // R3 xor clear
    {1'b0, 1'b1, 5'h06, 16'hABCD, 16'h0000},
    {1'b1, 1'b0, 5'h06, 16'h0000, 16'hABCD}, // R9 cal rw
    {1'b0, 1'b1, 5'h0D, 16'h1234, 16'h0000},
    {1'b1, 1'b0, 5'h0D, 16'h0000, 16'h1234}, // R9 ctrl A rw
    {1'b0, 1'b1, 5'h0E, 16'h5555, 16'h0000},
    {1'b1, 1'b0, 5'h0E, 16'h0000, 16'h5555}, // R9 ctrl B rw
    {1'b0, 1'b1, 5'h0A, 16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 5'h0D, 16'h0000, 16'h1234}, // R11 write to 0x0A leaves ctrl A
    {1'b1, 1'b0, 5'h0A, 16'h0000, 16'h0000}, // R11 reads zero
    {1'b0, 1'b1, 5'h03, 16'h7777, 16'h0000},
    {1'b1, 1'b0, 5'h03, 16'h0000, 16'h0000}, // R11 reads zero
    {1'b0, 1'b1, 5'h16, 16'h0000, 16'h0000},
    {1'b1, 1'b0, 5'h16, 16'h0000, 16'h0020}, // R9 status ignores writes
    {1'b0, 1'b1, 5'h01, 16'h0010, 16'h0000},
    {1'b1, 1'b0, 5'h01, 16'h0000, 16'h0000}, // R3 back to zero
    {1'b0, 1'b1, 5'h02, 16'hFFFF, 16'h0000},
    {1'b1, 1'b0, 5'h09, 16'h0000, 16'h0000}  // R7 sample flags reset
  };

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [4:0] idx, input logic [15:0] d);
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_write_i = w; acc_index_i = idx; acc_wdata_i = d;
    @(negedge clk_i);
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] idx, input string what, input logic [15:0] exp);
    acc(1'b0, idx, 16'h0);
    check(what, acc_rdata_o, exp);
  endtask

  task automatic adc_load(input logic [3:0] ch, input logic [9:0] v);
    @(negedge clk_i);
    adc_load_i = 1'b1; adc_load_chan_i = ch; adc_load_val_i = v;
    @(negedge clk_i);
    adc_load_i = 1'b0;
  endtask

  task automatic key(input logic pressed);
    @(negedge clk_i);
    key_event_i = 1'b1; key_pressed_i = pressed;
    @(negedge clk_i);
    key_event_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0; acc_valid_i = 1'b0; acc_write_i = 1'b0; acc_index_i = '0;
    acc_wdata_i = '0; key_event_i = 1'b0; key_pressed_i = 1'b0; adc_load_i = 1'b0;
    adc_load_chan_i = '0; adc_load_val_i = '0; smp_set_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R2 reset outputs
    check("R2 irq after reset", {15'd0, irq_o}, 16'h0);
    check("R2 rdata after reset", acc_rdata_o, 16'h0);
    check("R2 shutdown after reset", {15'd0, shutdown_req_o}, 16'h0);
    check("R2 bad after reset", {15'd0, bad_index_o}, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      acc(VEC[i][37], VEC[i][36:32], VEC[i][31:16]);
      if (VEC[i][38]) check($sformatf("table entry %0d", i), acc_rdata_o, VEC[i][15:0]);
    end

    // R1 level interrupt against mask
    acc(1'b1, 5'h01, 16'h0001);
    check("R1 masked flag no irq", {15'd0, irq_o}, 16'h0);
    acc(1'b1, 5'h02, 16'hFFFE);
    check("R1 unmasked flag irq", {15'd0, irq_o}, 16'h1);
    acc(1'b1, 5'h02, 16'hFFFF);
    check("R1 remask drops irq", {15'd0, irq_o}, 16'h0);
    acc(1'b1, 5'h01, 16'h0001);
    acc(1'b1, 5'h02, 16'hFFFE);
    check("R1 no flag no irq", {15'd0, irq_o}, 16'h0);
    acc(1'b1, 5'h02, 16'hFFFF);

    // R5 / R6 ADC channel select and readback
    adc_load(4'd3, 10'h165);
    acc(1'b1, 5'h08, 16'h0C00);
    rd(5'h08, "R6 channel 3 readback", 16'h0D65);
    rd(5'h01, "R5 adc done flag", 16'h0100);
    acc(1'b1, 5'h02, 16'hFEFF);
    check("R5 adc done irq", {15'd0, irq_o}, 16'h1);
    acc(1'b1, 5'h02, 16'hFFFF);
    acc(1'b1, 5'h01, 16'h0100);
    acc(1'b1, 5'h08, 16'h3C00);
    rd(5'h08, "R6 unloaded channel 15", 16'h3C00);
    adc_load(4'd15, 10'h3FF);
    rd(5'h08, "R6 full-scale channel 15", 16'h3FFF);
    acc(1'b1, 5'h01, 16'h0100);

    // R7 sample flags: set, clear, set wins
    @(negedge clk_i); smp_set_i = 16'h00FF;
    @(negedge clk_i); smp_set_i = 16'h0000;
    rd(5'h09, "R7 sample set", 16'h00FF);
    acc(1'b1, 5'h09, 16'h000F);
    rd(5'h09, "R7 write-one clear", 16'h00F0);
    @(negedge clk_i);
    smp_set_i = 16'h0001; acc_valid_i = 1'b1; acc_write_i = 1'b1;
    acc_index_i = 5'h09; acc_wdata_i = 16'h0001;
    @(negedge clk_i);
    smp_set_i = 16'h0000; acc_valid_i = 1'b0; acc_write_i = 1'b0;
    rd(5'h09, "R7 set beats clear", 16'h00F1);
    acc(1'b1, 5'h09, 16'hFFFF);
    rd(5'h09, "R7 clear all", 16'h0000);

    // R8 watchdog shutdown
    acc(1'b1, 5'h17, 16'h0000);
    check("R8 unarmed no shutdown", {15'd0, shutdown_req_o}, 16'h0);
    acc(1'b1, 5'h0D, 16'h0002);
    acc(1'b1, 5'h17, 16'h0005);
    check("R8 nonzero no shutdown", {15'd0, shutdown_req_o}, 16'h0);
    acc(1'b1, 5'h17, 16'h0000);
    check("R8 shutdown pulse", {15'd0, shutdown_req_o}, 16'h1);
    @(negedge clk_i);
    check("R8 shutdown one cycle", {15'd0, shutdown_req_o}, 16'h0);
    rd(5'h17, "R11 watchdog reads zero", 16'h0000);

    // R9 power key
    key(1'b1);
    rd(5'h16, "R9 key pressed status", 16'h0000);
    rd(5'h01, "R9 key flag", 16'h0001);
    key(1'b0);
    rd(5'h16, "R9 key released status", 16'h0020);

    // R12 key set in same cycle as xor clear
    @(negedge clk_i);
    key_event_i = 1'b1; key_pressed_i = 1'b0; acc_valid_i = 1'b1; acc_write_i = 1'b1;
    acc_index_i = 5'h01; acc_wdata_i = 16'h0001;
    @(negedge clk_i);
    key_event_i = 1'b0; acc_valid_i = 1'b0; acc_write_i = 1'b0;
    rd(5'h01, "R12 set beats xor clear", 16'h0001);
    acc(1'b1, 5'h01, 16'h0001);

    // R10 undefined indices
    rd(5'h07, "R10 undefined read zero", 16'h0000);
    check("R10 bad pulse on 0x07", {15'd0, bad_index_o}, 16'h1);
    @(negedge clk_i);
    check("R10 bad one cycle", {15'd0, bad_index_o}, 16'h0);
    acc(1'b1, 5'h15, 16'h1234);
    check("R10 bad pulse on 0x15", {15'd0, bad_index_o}, 16'h1);
    rd(5'h1F, "R11 index 0x1F reads zero", 16'h0000);
    check("R10 defined index no bad", {15'd0, bad_index_o}, 16'h0);

    // R13 read data held across writes
    rd(5'h06, "R13 read cal", 16'hABCD);
    acc(1'b1, 5'h0D, 16'h5A5A);
    check("R13 rdata held", acc_rdata_o, 16'hABCD);

    finish_run();
  end
endmodule